// File: doc/BRIEF.md
# Half-rate command serializer

This block connects a memory controller that runs at half the memory clock rate to a double-data-rate SDRAM bus. On every controller clock the controller presents each command signal as a two-slot word, one bit per memory clock. The block sends slot 0 out on the first memory clock of the pair and slot 1 on the second. Write data arrives as one packed word per controller cycle. That word holds a full four-beat burst for a byte-wide data bus. The block splits it into per-memory-clock beat pairs. Each pair holds two beats: the rising-edge beat in the low lane and the falling-edge beat in the high lane.

Commands can be placed in two ways. In word-aligned placement the chip select is active in slot 1 (pair value 2'b01), and a burst word goes out entirely within its own controller cycle. In word-unaligned placement the chip select is active in slot 0 (pair value 2'b10). The burst is then shifted by one memory clock: its first two beats go out in slot 1, and its last two beats are held in a register and go out in slot 0 of the next controller cycle. A configuration input selects the placement. The block samples that input only on an idle cycle.

The memory clock runs at twice the controller clock frequency and is synchronous to it, with every second rising edge shared. Both clock domains share one asynchronous active-low reset.

Top module: `hr_cmd_serializer`

## Requirements
- R1: While reset is asserted, mem_cs_n, mem_ras_n, mem_cas_n and mem_we_n are 1, mem_addr is 0, mem_dq is 0 and mem_dq_oe is 0.
- R2: For a controller word captured at a controller clock edge, slot 0 (bit 0 of each control pair, and ctl_addr[ADDR_W-1:0]) drives the outputs from the memory clock edge midway through that controller cycle. Slot 1 (bit 1, and ctl_addr[2*ADDR_W-1:ADDR_W]) drives them from the next controller clock edge.
- R3: In aligned mode (cfg_unaligned latched as 0), a valid burst word goes out in its own controller cycle. Slot 0 carries {ctl_wdata[15:8], ctl_wdata[7:0]} and slot 1 carries {ctl_wdata[31:24], ctl_wdata[23:16]} on mem_dq, where the low lane is the earlier beat. mem_dq_oe is 1 in both slots. Lane widths are shown for DQ_W = 8.
- R4: In unaligned mode (latched as 1), the low half of a valid word goes out in slot 1 of its cycle. The high half goes out in slot 0 of the following cycle. mem_dq_oe is 1 in exactly those two slots.
- R5: Unaligned burst words on consecutive controller cycles form one continuous beat stream, with no beat dropped, repeated or reordered.
- R6: Commands separated by one idle controller cycle, reads as well as writes and in either mode, leave the idle cycle's slots with every control output at 1, apart from a pending unaligned data spill.
- R7: In any slot that carries no burst beats, mem_dq_oe is 0 and mem_dq is 0.
- R8: The placement mode is latched from cfg_unaligned only in a controller cycle with ctl_wdata_valid low and no pending high half. A value presented on cfg_unaligned in any other cycle has no effect on the data mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Controller clock (half rate) |
| mem_clk | input | 1 | Memory clock, twice ctl_clk, edge-aligned |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_unaligned | input | 1 | Placement select: 1 unaligned, 0 aligned |
| ctl_cs_n | input | 2 | Chip-select slot pair, bit 0 first |
| ctl_ras_n | input | 2 | Row strobe slot pair |
| ctl_cas_n | input | 2 | Column strobe slot pair |
| ctl_we_n | input | 2 | Write enable slot pair |
| ctl_addr | input | 2*ADDR_W | Address slot pair, slot 0 in low half |
| ctl_wdata | input | 4*DQ_W | Four-beat burst word, beat 0 in low byte |
| ctl_wdata_valid | input | 1 | Burst word present this cycle |
| mem_cs_n | output | 1 | Serialized chip select |
| mem_ras_n | output | 1 | Serialized row strobe |
| mem_cas_n | output | 1 | Serialized column strobe |
| mem_we_n | output | 1 | Serialized write enable |
| mem_addr | output | ADDR_W | Serialized address |
| mem_dq | output | 2*DQ_W | Beat pair for this memory clock, earlier beat low |
| mem_dq_oe | output | 1 | Data output enable |

## Verification
The bench builds the block with DQ_W = 8, which gives the byte-wide bus and 32-bit burst word of the intended use. It uses ADDR_W = 6, so that slot-0 and slot-1 addresses are short distinct patterns whose swap is visible in every slot. Each scenario drives the controller on every cycle without a break. A model inside the bench predicts every memory-clock slot from the requirements. This exposes the half-cycle spill across back-to-back unaligned words, the idle gaps of spaced commands, and mode requests made while a word is still in flight.

// File: rtl/hr_cmd_serializer.sv
module hr_cmd_serializer #(
  parameter int DQ_W   = 8,
  parameter int ADDR_W = 14
) (
  input  logic                  ctl_clk,
  input  logic                  mem_clk,
  input  logic                  rst_n,
  input  logic                  cfg_unaligned,
  input  logic [1:0]            ctl_cs_n,
  input  logic [1:0]            ctl_ras_n,
  input  logic [1:0]            ctl_cas_n,
  input  logic [1:0]            ctl_we_n,
  input  logic [2*ADDR_W-1:0]   ctl_addr,
  input  logic [4*DQ_W-1:0]     ctl_wdata,
  input  logic                  ctl_wdata_valid,
  output logic                  mem_cs_n,
  output logic                  mem_ras_n,
  output logic                  mem_cas_n,
  output logic                  mem_we_n,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [2*DQ_W-1:0]     mem_dq,
  output logic                  mem_dq_oe
);

  localparam int PAIR_W = 2 * DQ_W;
  localparam int WORD_W = 4 * DQ_W;

  logic [1:0]          cs_q, ras_q, cas_q, we_q;
  logic [2*ADDR_W-1:0] addr_q;
  logic [PAIR_W-1:0]   s0_q, s1_q, hold_q;
  logic                oe0_q, oe1_q, hold_v, unal_q;
  logic                tgl_c, tgl_m;

  wire                 idle_in = !ctl_wdata_valid && !hold_v;
  wire [PAIR_W-1:0]    lo = ctl_wdata_valid ? ctl_wdata[PAIR_W-1:0] : '0;
  wire [PAIR_W-1:0]    hi = ctl_wdata_valid ? ctl_wdata[WORD_W-1:PAIR_W] : '0;
  wire                 mid = tgl_c ^ tgl_m;

  always_ff @(posedge ctl_clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_c  <= 1'b0;
      cs_q   <= 2'b11;
      ras_q  <= 2'b11;
      cas_q  <= 2'b11;
      we_q   <= 2'b11;
      addr_q <= '0;
      s0_q   <= '0;
      s1_q   <= '0;
      hold_q <= '0;
      oe0_q  <= 1'b0;
      oe1_q  <= 1'b0;
      hold_v <= 1'b0;
      unal_q <= 1'b0;
    end else begin
      tgl_c  <= ~tgl_c;
      cs_q   <= ctl_cs_n;
      ras_q  <= ctl_ras_n;
      cas_q  <= ctl_cas_n;
      we_q   <= ctl_we_n;
      addr_q <= ctl_addr;
      if (idle_in) unal_q <= cfg_unaligned;
      if (unal_q) begin
        s0_q   <= hold_q;
        oe0_q  <= hold_v;
        s1_q   <= lo;
        oe1_q  <= ctl_wdata_valid;
        hold_q <= hi;
        hold_v <= ctl_wdata_valid;
      end else begin
        s0_q   <= lo;
        oe0_q  <= ctl_wdata_valid;
        s1_q   <= hi;
        oe1_q  <= ctl_wdata_valid;
        hold_q <= '0;
        hold_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge mem_clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_m     <= 1'b0;
      mem_cs_n  <= 1'b1;
      mem_ras_n <= 1'b1;
      mem_cas_n <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_addr  <= '0;
      mem_dq    <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      tgl_m <= tgl_c;
      if (mid) begin
        mem_cs_n  <= cs_q[0];
        mem_ras_n <= ras_q[0];
        mem_cas_n <= cas_q[0];
        mem_we_n  <= we_q[0];
        mem_addr  <= addr_q[ADDR_W-1:0];
        mem_dq    <= s0_q;
        mem_dq_oe <= oe0_q;
      end else begin
        mem_cs_n  <= cs_q[1];
        mem_ras_n <= ras_q[1];
        mem_cas_n <= cas_q[1];
        mem_we_n  <= we_q[1];
        mem_addr  <= addr_q[2*ADDR_W-1:ADDR_W];
        mem_dq    <= s1_q;
        mem_dq_oe <= oe1_q;
      end
    end
  end

endmodule

// File: rtl/hr_cmd_serializer_chk.sv
module hr_cmd_serializer_chk #(
  parameter int DQ_W = 8
) (
  input logic              ctl_clk,
  input logic              mem_clk,
  input logic              rst_n,
  input logic              ctl_wdata_valid,
  input logic [2*DQ_W-1:0] wdata_hi,
  input logic              unal_q,
  input logic              hold_v,
  input logic [2*DQ_W-1:0] hold_q,
  input logic              mid,
  input logic [1:0]        cs_q,
  input logic              mem_cs_n,
  input logic [2*DQ_W-1:0] mem_dq,
  input logic              mem_dq_oe
);

  a_r2_first_slot: assert property (@(posedge mem_clk) disable iff (!rst_n)
    mid |=> (mem_cs_n == $past(cs_q[0])));

  a_r2_second_slot: assert property (@(posedge mem_clk) disable iff (!rst_n)
    !mid |=> (mem_cs_n == $past(cs_q[1])));

  a_r4_hold_capture: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    (unal_q && ctl_wdata_valid) |=> (hold_v && hold_q == $past(wdata_hi)));

  a_r7_quiet_bus: assert property (@(posedge mem_clk) disable iff (!rst_n)
    !mem_dq_oe |-> (mem_dq == '0));

  a_r8_mode_frozen: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    (ctl_wdata_valid || hold_v) |=> $stable(unal_q));

endmodule

bind hr_cmd_serializer hr_cmd_serializer_chk #(.DQ_W(DQ_W)) chk_i (
  .ctl_clk         (ctl_clk),
  .mem_clk         (mem_clk),
  .rst_n           (rst_n),
  .ctl_wdata_valid (ctl_wdata_valid),
  .wdata_hi        (ctl_wdata[4*DQ_W-1:2*DQ_W]),
  .unal_q          (unal_q),
  .hold_v          (hold_v),
  .hold_q          (hold_q),
  .mid             (mid),
  .cs_q            (cs_q),
  .mem_cs_n        (mem_cs_n),
  .mem_dq          (mem_dq),
  .mem_dq_oe       (mem_dq_oe)
);

// File: tb/hr_cmd_serializer_tb_top.sv
`timescale 1ns/1ps
module hr_cmd_serializer_tb_top;
  localparam int CLK_PERIOD = 8;
  localparam int DQ_W   = 8;
  localparam int ADDR_W = 6;
  localparam int PW     = 2 * DQ_W;
  localparam int WW     = 4 * DQ_W;
  localparam int EW     = 4 + ADDR_W + PW + 1;

  logic ctl_clk, mem_clk, rst_n, cfg_unaligned, ctl_wdata_valid;
  logic [1:0] ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n;
  logic [2*ADDR_W-1:0] ctl_addr;
  logic [WW-1:0] ctl_wdata;
  logic mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
  logic [ADDR_W-1:0] mem_addr;
  logic [PW-1:0] mem_dq;

  hr_cmd_serializer #(.DQ_W(DQ_W), .ADDR_W(ADDR_W)) dut_i (
    .ctl_clk(ctl_clk), .mem_clk(mem_clk), .rst_n(rst_n),
    .cfg_unaligned(cfg_unaligned),
    .ctl_cs_n(ctl_cs_n), .ctl_ras_n(ctl_ras_n), .ctl_cas_n(ctl_cas_n),
    .ctl_we_n(ctl_we_n), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .ctl_wdata_valid(ctl_wdata_valid),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq(mem_dq),
    .mem_dq_oe(mem_dq_oe)
  );

  initial begin ctl_clk = 1'b1; forever #(CLK_PERIOD/2) ctl_clk = ~ctl_clk; end
  initial begin mem_clk = 1'b1; forever #(CLK_PERIOD/4) mem_clk = ~mem_clk; end

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string cur_tag = "R2";

  logic [EW-1:0] exp_q[$];
  time           due_q[$];
  string         tag_q[$];

  bit            m_unal = 0;
  bit            m_hv = 0;
  logic [PW-1:0] m_hold = '0;

  wire [EW-1:0] act_bus = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n,
                           mem_addr, mem_dq, mem_dq_oe};

  task automatic check(input string tag, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] cs, input logic [1:0] ras, input logic [1:0] cas,
                     input logic [1:0] we, input logic [ADDR_W-1:0] a0,
                     input logic [ADDR_W-1:0] a1, input logic [WW-1:0] wd,
                     input logic v, input logic md);
    logic [PW-1:0] lo, hi, d0, d1;
    logic o0, o1, idle_now;
    @(negedge ctl_clk);
    ctl_cs_n = cs; ctl_ras_n = ras; ctl_cas_n = cas; ctl_we_n = we;
    ctl_addr = {a1, a0}; ctl_wdata = wd; ctl_wdata_valid = v; cfg_unaligned = md;
    lo = v ? wd[PW-1:0] : '0;
    hi = v ? wd[WW-1:PW] : '0;
    if (!m_unal) begin d0 = lo; o0 = v; d1 = hi; o1 = v; end
    else begin d0 = m_hold; o0 = m_hv; d1 = lo; o1 = v; end
    exp_q.push_back({cs[0], ras[0], cas[0], we[0], a0, d0, o0});
    due_q.push_back($time + CLK_PERIOD*5/4);
    tag_q.push_back(cur_tag);
    exp_q.push_back({cs[1], ras[1], cas[1], we[1], a1, d1, o1});
    due_q.push_back($time + CLK_PERIOD*7/4);
    tag_q.push_back(cur_tag);
    idle_now = !v && !m_hv;
    if (m_unal) begin m_hold = hi; m_hv = v; end
    else begin m_hold = '0; m_hv = 0; end
    if (idle_now) m_unal = md;
  endtask

  task automatic wr(input bit sl1, input logic [ADDR_W-1:0] a, input logic [WW-1:0] d, input logic md);
    logic [1:0] p;
    p = sl1 ? 2'b01 : 2'b10;
    cyc(p, 2'b11, p, p, sl1 ? '0 : a, sl1 ? a : '0, d, 1'b1, md);
  endtask

  task automatic rd(input bit sl1, input logic [ADDR_W-1:0] a, input logic md);
    logic [1:0] p;
    p = sl1 ? 2'b01 : 2'b10;
    cyc(p, 2'b11, p, 2'b11, sl1 ? '0 : a, sl1 ? a : '0, '0, 1'b0, md);
  endtask

  task automatic idle(input logic md);
    cyc(2'b11, 2'b11, 2'b11, 2'b11, '0, '0, '0, 1'b0, md);
  endtask

  initial begin
    forever begin
      @(negedge mem_clk);
      while (due_q.size() > 0 && due_q[0] <= $time) begin
        check(tag_q[0], act_bus, exp_q[0]);
        void'(exp_q.pop_front());
        void'(due_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic t_reset();
    #(CLK_PERIOD*3);
    check("R1 reset", act_bus, {4'b1111, {ADDR_W{1'b0}}, {PW{1'b0}}, 1'b0});
    @(negedge ctl_clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_aligned_b2b();
    cur_tag = "R2 R3";
    idle(0);
    wr(1, 6'h15, 32'h44332211, 0);
    wr(1, 6'h2A, 32'hDDCCBBAA, 0);
    wr(1, 6'h3C, 32'h0F1E2D3C, 0);
    rd(1, 6'h07, 0);
    idle(0);
  endtask

  task automatic t_aligned_spaced();
    cur_tag = "R6 R7";
    wr(1, 6'h11, 32'hA1B2C3D4, 0);
    idle(0);
    wr(1, 6'h22, 32'h5A6B7C8D, 0);
    idle(0);
    rd(1, 6'h33, 0);
    idle(0);
    rd(1, 6'h0C, 0);
    idle(0);
  endtask

  task automatic t_guard_aligned();
    cur_tag = "R8 busy request while aligned";
    wr(1, 6'h01, 32'h13572468, 1);
    wr(1, 6'h02, 32'h9BDF0ACE, 1);
    idle(0);
    wr(1, 6'h03, 32'h55AA33CC, 0);
    idle(0);
  endtask

  task automatic t_unaligned_single();
    cur_tag = "R8 idle latch";
    idle(1);
    cur_tag = "R4";
    wr(0, 6'h19, 32'hCAFEF00D, 1);
    idle(1);
    idle(1);
  endtask

  task automatic t_unaligned_b2b();
    cur_tag = "R5";
    wr(0, 6'h21, 32'h04030201, 1);
    wr(0, 6'h22, 32'h08070605, 1);
    wr(0, 6'h23, 32'h0C0B0A09, 1);
    wr(0, 6'h24, 32'h100F0E0D, 1);
    idle(1);
    idle(1);
  endtask

  task automatic t_unaligned_spaced();
    cur_tag = "R6 unaligned";
    wr(0, 6'h2E, 32'h87654321, 1);
    idle(1);
    rd(0, 6'h1D, 1);
    idle(1);
    wr(0, 6'h3F, 32'hFEDCBA98, 1);
    idle(1);
    idle(1);
  endtask

  task automatic t_guard_unaligned();
    cur_tag = "R8 busy request while unaligned";
    wr(0, 6'h09, 32'h600DBEEF, 0);
    idle(0);
    idle(0);
    cur_tag = "R3 after return";
    wr(1, 6'h0A, 32'h76543210, 0);
    idle(0);
    idle(0);
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_unaligned = 1'b0;
    ctl_cs_n = 2'b11; ctl_ras_n = 2'b11; ctl_cas_n = 2'b11; ctl_we_n = 2'b11;
    ctl_addr = '0; ctl_wdata = '0; ctl_wdata_valid = 1'b0;
    t_reset();
    t_aligned_b2b();
    t_aligned_spaced();
    t_guard_aligned();
    t_unaligned_single();
    t_unaligned_b2b();
    t_unaligned_spaced();
    t_guard_unaligned();
    #(CLK_PERIOD*3);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule